// File: doc/BRIEF.md
# Instruction Fetch Stage with Branch Squash

This block is the front stage of a five-stage in-order pipeline. It owns the program counter and drives the address of a synchronous instruction memory. The word for an address comes back on the cycle after that address is driven. Each cycle the stage presents one 32-bit instruction, its address and a live flag to the decode stage.

Decode looks at the word the stage is presenting and answers in the same cycle whether that word is a branch, whether it is taken, and where it goes. The word after the branch is always fetched. A run-time policy input decides whether that word is kept. Under the fall-through policy it is kept when the branch is not taken. Under the likely policy it is kept when the branch is taken. A discarded word goes on as a NOP with the live flag low, so a wrong guess costs exactly one issue slot. An exception input steers fetch to a vector address and overrides everything else. A stall input freezes the stage.

Top module: `fetch_squash_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, the stage presents address RESET_VEC, the live flag low and the NOP_WORD instruction. In the next cycle it presents the memory word at RESET_VEC with the live flag high.
- R2: With no stall, exception or pending redirect, the presented address rises by 4 each cycle. The presented instruction is the memory word at the presented address.
- R3: With the fall-through policy (likely_mode_i = 0), a taken branch makes the next presented word (branch address + 4) a NOP with the live flag low. The cycle after that presents the branch target with the live flag high.
- R4: With the fall-through policy, a not-taken branch keeps the word at branch address + 4 live. Fetch continues in sequence with no lost slot.
- R5: With the likely policy (likely_mode_i = 1), a taken branch keeps the word at branch address + 4 live. The branch target follows in the next cycle.
- R6: With the likely policy, a not-taken branch makes the word at branch address + 4 a NOP with the live flag low. Sequential fetch continues at branch address + 8.
- R7: While stall_i is high and no exception is raised, the presented address, instruction and live flag hold. Branch inputs given in a stalled cycle have no effect.
- R8: An exception in a cycle makes the next cycle present exc_vector_i with the live flag high. This holds even under stall or a concurrent branch, and it cancels any branch redirect still pending.
- R9: Branch inputs are ignored while the presented word is not live, and while a redirect from an earlier branch is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Hold the stage this cycle |
| likely_mode_i | input | 1 | Policy for the slot word: 0 keeps it when not taken, 1 keeps it when taken |
| br_valid_i | input | 1 | The presented word is a resolved branch or jump |
| br_taken_i | input | 1 | The branch is taken |
| br_target_i | input | ADDR_W | Branch target address |
| exc_valid_i | input | 1 | Exception redirect request |
| exc_vector_i | input | ADDR_W | Exception vector address |
| imem_addr_o | output | ADDR_W | Address to the synchronous instruction memory |
| imem_rdata_i | input | INSTR_W | Memory word for the previous cycle's address |
| fetch_instr_o | output | INSTR_W | Instruction to decode, NOP when squashed |
| fetch_pc_o | output | ADDR_W | Address of the presented instruction |
| fetch_valid_o | output | 1 | Presented instruction is live |

## Verification
The overlaps that matter are a redirect meeting a second event in the same cycle. An exception is raised together with a taken branch. An exception arrives while a taken fall-through branch still has its target pending. An exception is raised under stall. A stall or a second branch lands on the slot word of a branch. Each is driven as one row of the stimulus table. The result is judged from the address sequence and live flags that follow. The vector must win, the stale target must never appear, and ignored branch targets must never be presented.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  // Policy applied to the word that follows a resolved branch
  typedef enum logic {
    POL_FALLTHRU = 1'b0,  // keep slot word when the branch is not taken
    POL_LIKELY   = 1'b1   // keep slot word when the branch is taken
  } policy_e;

endpackage

// File: rtl/fetch_policy.sv
module fetch_policy
  import fetch_pkg::*;
(
  input  logic    accept_i,
  input  logic    taken_i,
  input  policy_e mode_i,
  output logic    squash_o,
  output logic    redirect_o
);

  // The slot word is discarded when the outcome disagrees with the policy's guess
  always_comb begin
    squash_o   = 1'b0;
    redirect_o = accept_i & taken_i;
    if (accept_i) begin
      unique case (mode_i)
        POL_FALLTHRU: squash_o = taken_i;
        POL_LIKELY:   squash_o = ~taken_i;
        default:      squash_o = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/fetch_next_pc.sv
module fetch_next_pc #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned STEP      = 4,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input  logic              rst,
  input  logic              exc_i,
  input  logic [ADDR_W-1:0] exc_vec_i,
  input  logic              stall_i,
  input  logic              boot_i,
  input  logic              redir_i,
  input  logic [ADDR_W-1:0] tgt_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] pc_next_o
);

  localparam logic [ADDR_W-1:0] INC = ADDR_W'(STEP);

  // Priority: reset, exception, stall/boot hold, pending branch, sequential
  always_comb begin
    if (rst)                   pc_next_o = RESET_VEC;
    else if (exc_i)            pc_next_o = exc_vec_i;
    else if (stall_i || boot_i) pc_next_o = pc_i;
    else if (redir_i)          pc_next_o = tgt_i;
    else                       pc_next_o = pc_i + INC;
  end

endmodule

// File: rtl/fetch_out.sv
module fetch_out #(
  parameter int unsigned INSTR_W = 32,
  parameter logic [INSTR_W-1:0] NOP_WORD = '0
) (
  input  logic               live_i,
  input  logic [INSTR_W-1:0] word_i,
  output logic [INSTR_W-1:0] instr_o
);

  // Memory output is already registered; only a select follows it
  assign instr_o = live_i ? word_i : NOP_WORD;

endmodule

// File: rtl/fetch_squash_unit.sv
module fetch_squash_unit
  import fetch_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned INSTR_W   = 32,
  parameter logic [ADDR_W-1:0]  RESET_VEC = 32'h0000_1000,
  parameter logic [INSTR_W-1:0] NOP_WORD  = 32'h0000_0013
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stall_i,
  input  logic               likely_mode_i,
  input  logic               br_valid_i,
  input  logic               br_taken_i,
  input  logic [ADDR_W-1:0]  br_target_i,
  input  logic               exc_valid_i,
  input  logic [ADDR_W-1:0]  exc_vector_i,
  output logic [ADDR_W-1:0]  imem_addr_o,
  input  logic [INSTR_W-1:0] imem_rdata_i,
  output logic [INSTR_W-1:0] fetch_instr_o,
  output logic [ADDR_W-1:0]  fetch_pc_o,
  output logic               fetch_valid_o
);

  localparam int unsigned STEP = INSTR_W / 8;

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] tgt_q;
  logic [ADDR_W-1:0] pc_next;
  logic              valid_q;
  logic              redir_q;
  logic              boot_q;
  logic              accept;
  logic              squash;
  logic              redirect;
  policy_e           mode;

  assign mode   = policy_e'(likely_mode_i);
  assign accept = br_valid_i & valid_q & ~redir_q & ~stall_i & ~exc_valid_i;

  fetch_policy u_policy (
    .accept_i   (accept),
    .taken_i    (br_taken_i),
    .mode_i     (mode),
    .squash_o   (squash),
    .redirect_o (redirect)
  );

  fetch_next_pc #(
    .ADDR_W    (ADDR_W),
    .STEP      (STEP),
    .RESET_VEC (RESET_VEC)
  ) u_next (
    .rst       (rst),
    .exc_i     (exc_valid_i),
    .exc_vec_i (exc_vector_i),
    .stall_i   (stall_i),
    .boot_i    (boot_q),
    .redir_i   (redir_q),
    .tgt_i     (tgt_q),
    .pc_i      (pc_q),
    .pc_next_o (pc_next)
  );

  assign imem_addr_o = pc_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= RESET_VEC;
      tgt_q   <= RESET_VEC;
      valid_q <= 1'b0;
      redir_q <= 1'b0;
      boot_q  <= 1'b1;
    end else if (exc_valid_i) begin
      pc_q    <= pc_next;
      valid_q <= 1'b1;
      redir_q <= 1'b0;
      boot_q  <= 1'b0;
    end else if (!stall_i) begin
      pc_q    <= pc_next;
      boot_q  <= 1'b0;
      if (redir_q) begin
        valid_q <= 1'b1;
        redir_q <= 1'b0;
      end else begin
        valid_q <= ~squash;
        redir_q <= redirect;
        if (redirect) tgt_q <= br_target_i;
      end
    end
  end

  fetch_out #(
    .INSTR_W  (INSTR_W),
    .NOP_WORD (NOP_WORD)
  ) u_out (
    .live_i  (valid_q),
    .word_i  (imem_rdata_i),
    .instr_o (fetch_instr_o)
  );

  assign fetch_pc_o    = pc_q;
  assign fetch_valid_o = valid_q;

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && !exc_valid_i && !redir_q && !boot_q) |=> (pc_q == $past(pc_q) + ADDR_W'(STEP)));

  // R3
  fallthru_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && br_taken_i && !likely_mode_i) |=> (!fetch_valid_o && redir_q));

  // R5
  target_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (redir_q && !stall_i && !exc_valid_i) |=> (fetch_pc_o == $past(tgt_q) && fetch_valid_o));

  // R6
  likely_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !br_taken_i && likely_mode_i) |=> (!fetch_valid_o && !redir_q));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stall_i && !exc_valid_i) |=> ($stable(fetch_pc_o) && $stable(fetch_valid_o) && $stable(redir_q)));

  // R8
  exc_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    exc_valid_i |=> (fetch_pc_o == $past(exc_vector_i) && fetch_valid_o && !redir_q));

  // R9
  branch_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!valid_q && !redir_q && !exc_valid_i) |=> !redir_q);

endmodule

// File: tb/test_fetch_squash_unit.sv
module test_fetch_squash_unit;

  localparam logic [31:0] RV  = 32'h0000_1000;
  localparam logic [31:0] NOP = 32'h0000_0013;

  typedef struct packed {
    logic        st;
    logic        ex;
    logic        bv;
    logic        bt;
    logic        md;
    logic [31:0] a;
    logic [31:0] pc;
    logic        v;
    logic [3:0]  rq;
  } row_t;

  // Each row: expected outputs this cycle, then inputs applied this cycle
  localparam row_t TAB [19] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h1000,1'b0,4'd1}, // R1 first cycle
    '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h1000,1'b1,4'd1}, // R1 word at vector
    '{1'b0,1'b0,1'b1,1'b1,1'b0,32'h2000,32'h1004,1'b1,4'd2}, // R2, taken fall-through
    '{1'b0,1'b0,1'b1,1'b1,1'b0,32'h3000,32'h1008,1'b0,4'd3}, // R3 slot squashed
    '{1'b0,1'b0,1'b1,1'b0,1'b0,32'h0,   32'h2000,1'b1,4'd3}, // R3 target
    '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h2004,1'b1,4'd4}, // R4 slot kept
    '{1'b0,1'b0,1'b1,1'b1,1'b1,32'h4000,32'h2008,1'b1,4'd2}, // R2, likely taken
    '{1'b0,1'b0,1'b1,1'b1,1'b1,32'h5000,32'h200C,1'b1,4'd5}, // R5 slot kept
    '{1'b0,1'b0,1'b1,1'b0,1'b1,32'h0,   32'h4000,1'b1,4'd9}, // R9 5000 ignored
    '{1'b0,1'b0,1'b0,1'b0,1'b1,32'h0,   32'h4004,1'b0,4'd6}, // R6 slot squashed
    '{1'b1,1'b0,1'b0,1'b0,1'b1,32'h0,   32'h4008,1'b1,4'd6}, // R6 sequential
    '{1'b1,1'b0,1'b1,1'b1,1'b1,32'h6000,32'h4008,1'b1,4'd7}, // R7 held
    '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h4008,1'b1,4'd7}, // R7 held
    '{1'b0,1'b1,1'b1,1'b1,1'b0,32'h0200,32'h400C,1'b1,4'd7}, // R7 6000 ignored
    '{1'b0,1'b0,1'b1,1'b1,1'b0,32'h8000,32'h0200,1'b1,4'd8}, // R8 beats branch
    '{1'b1,1'b1,1'b0,1'b0,1'b0,32'h0300,32'h0204,1'b0,4'd3}, // R3 squashed slot
    '{1'b1,1'b1,1'b0,1'b0,1'b0,32'h0400,32'h0300,1'b1,4'd8}, // R8 cancels 8000
    '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h0400,1'b1,4'd8}, // R8 beats stall
    '{1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,   32'h0404,1'b1,4'd2}  // R2
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall_i = 1'b0;
  logic        likely_mode_i = 1'b0;
  logic        br_valid_i = 1'b0;
  logic        br_taken_i = 1'b0;
  logic [31:0] br_target_i = '0;
  logic        exc_valid_i = 1'b0;
  logic [31:0] exc_vector_i = '0;
  logic [31:0] imem_addr_o;
  logic [31:0] imem_rdata_i = '0;
  logic [31:0] fetch_instr_o;
  logic [31:0] fetch_pc_o;
  logic        fetch_valid_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fetch_squash_unit i_fetch_squash_unit (
    .clk           (clk),
    .rst           (rst),
    .stall_i       (stall_i),
    .likely_mode_i (likely_mode_i),
    .br_valid_i    (br_valid_i),
    .br_taken_i    (br_taken_i),
    .br_target_i   (br_target_i),
    .exc_valid_i   (exc_valid_i),
    .exc_vector_i  (exc_vector_i),
    .imem_addr_o   (imem_addr_o),
    .imem_rdata_i  (imem_rdata_i),
    .fetch_instr_o (fetch_instr_o),
    .fetch_pc_o    (fetch_pc_o),
    .fetch_valid_o (fetch_valid_o)
  );

  function automatic logic [31:0] word_of(logic [31:0] a);
    return 32'hC0DE_0000 ^ {16'h0, a[15:0]};
  endfunction

  always @(posedge clk) imem_rdata_i <= word_of(imem_addr_o);

  function automatic string rq_name(logic [3:0] n);
    case (n)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic check_out(string rq, logic [31:0] pc, logic v);
    check(rq, "pc", fetch_pc_o, pc);
    check(rq, "valid", {31'b0, fetch_valid_o}, {31'b0, v});
    check(rq, "instr", fetch_instr_o, v ? word_of(pc) : NOP);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_out("R1", RV, 1'b0);
    rst = 1'b0;
    for (int k = 0; k < 19; k++) begin
      check_out(rq_name(TAB[k].rq), TAB[k].pc, TAB[k].v);
      stall_i       = TAB[k].st;
      exc_valid_i   = TAB[k].ex;
      br_valid_i    = TAB[k].bv;
      br_taken_i    = TAB[k].bt;
      likely_mode_i = TAB[k].md;
      br_target_i   = TAB[k].a;
      exc_vector_i  = TAB[k].a;
      @(negedge clk);
    end
    check_out("R2", 32'h0408, 1'b1);
    // Directed: reset in mid-run
    rst = 1'b1;
    @(negedge clk);
    check_out("R1", RV, 1'b0);
    @(negedge clk);
    check_out("R1", RV, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check_out("R1", RV, 1'b1);
    @(negedge clk);
    check_out("R2", RV + 32'd4, 1'b1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule